// File: doc/BRIEF.md
# User Interrupt Enable Flag Controller

This block keeps the per-core enable flag for user-level interrupts and executes the three instructions that act on it. The three instructions clear the flag, set the flag, or report it. Each one arrives as a one-cycle strobe with a 2-bit operation select. The strobe comes with the core's current status: whether the feature is switched on, whether the core runs in 64-bit mode, whether it executes inside an enclave, and whether it is inside a transactional region.

A legal clear or set changes the flag at the next clock edge. The delivery gate follows the flag at that same edge, so the next instruction boundary already sees the new state. All three instructions raise an invalid-opcode pulse if the feature is off, the core is not in 64-bit mode, or the core is in an enclave. A clear or set issued inside a transaction does not change the flag. It raises a transactional-abort pulse with a 32-bit code instead, and the code depends on which of the two instructions caused the abort. The report instruction works inside transactions. It returns the flag as the carry bit of an arithmetic-flags word and forces every other bit of that word to zero.

Top module: `usr_irq_flag_ctl`

## Requirements
- R1: With `op_valid` high, the core legal (feature on, 64-bit mode, not in an enclave) and `in_txn` low, the select code 2'b01 (clear) makes `flag_q` 0 and the code 2'b10 (set) makes it 1, starting in the next cycle.
- R2: `deliver_gate` equals the updated flag in the cycle right after a clear or set, so it is low after a legal clear and high after a legal set.
- R3: If the feature bit is 0, or `long_mode` is 0, or `in_enclave` is 1, any of the codes 2'b01, 2'b10 or 2'b11 gives a one-cycle `ud_exc` pulse in the next cycle. In that case the flag stays unchanged and `txn_abort` and `test_vld` stay low. This holds even when `in_txn` is also 1.
- R4: A legal clear or set with `in_txn` high leaves the flag unchanged and gives a one-cycle `txn_abort` pulse in the next cycle. During that pulse `abort_code` is 32'h0000_0101 for a clear and 32'h0000_0103 for a set. At all other times `abort_code` is 0.
- R5: A legal report (code 2'b11) gives a one-cycle `test_vld` pulse in the next cycle, whether or not `in_txn` is high. During the pulse `test_result` equals the flag, and `test_flags` carries the flag in bit 0 (carry) and zeros in bits 1 to 5 (parity, auxiliary, zero, sign, overflow). `test_flags` is 0 when there is no pulse.
- R6: With `op_valid` low or code 2'b00, no pulse is raised and the flag keeps its value.
- R7: While synchronous reset `rst` is high, the flag, the gate, every pulse, `test_flags` and `abort_code` are 0.
- R8: Every pulse output is registered and lasts exactly one cycle for each strobe. At most one of `ud_exc`, `txn_abort` and `test_vld` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction strobe |
| op_sel | input | 2 | 01 clear, 10 set, 11 report, 00 none |
| feat_en | input | 1 | Feature enable status bit |
| long_mode | input | 1 | Core is in 64-bit mode |
| in_enclave | input | 1 | Core executes inside an enclave |
| in_txn | input | 1 | Core is inside a transactional region |
| flag_q | output | 1 | User interrupt enable flag |
| deliver_gate | output | 1 | Allows user-interrupt delivery at the next boundary |
| ud_exc | output | 1 | Invalid-opcode pulse |
| txn_abort | output | 1 | Transactional-abort pulse |
| abort_code | output | 32 | Abort code, valid with `txn_abort` |
| test_vld | output | 1 | Report result pulse |
| test_result | output | 1 | Flag value returned by the report |
| test_flags | output | 6 | Arithmetic flags word from the report |

## Verification
The properties assume that the status inputs are stable while `op_valid` is high. They also assume that a strobe is one cycle wide and that reset is held for at least one clock edge. The bench drives each strobe on a falling edge and holds it for exactly one rising edge. It then drops `op_valid` at the next falling edge, which keeps every input inside those assumptions. Status combinations that are illegal and inside a transaction at the same time are applied on purpose, to confirm that the exception takes priority over the abort.

// File: rtl/usr_irq_flag_pkg.sv
package usr_irq_flag_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_CLEAR = 2'b01,
        OP_SET   = 2'b10,
        OP_TEST  = 2'b11
    } uflag_op_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_WRITE,
        ACT_ABORT,
        ACT_FAULT,
        ACT_REPORT
    } uflag_act_e;

    typedef struct packed {
        logic feat_en;
        logic long_mode;
        logic in_enclave;
        logic in_txn;
    } core_mode_t;

    // bit 0 carry, 1 parity, 2 auxiliary, 3 zero, 4 sign, 5 overflow
    typedef struct packed {
        logic of_b;
        logic sf_b;
        logic zf_b;
        logic af_b;
        logic pf_b;
        logic cf_b;
    } arith_flags_t;

    typedef struct packed {
        uflag_act_e act;
        logic       new_val;
        logic       abort_is_set;
    } uflag_decision_t;

    function automatic logic mode_forbids(input core_mode_t m);
        return !(m.feat_en && m.long_mode && !m.in_enclave);
    endfunction

    function automatic arith_flags_t report_flags(input logic val);
        arith_flags_t f;
        f = '0;
        f.cf_b = val;
        return f;
    endfunction

endpackage

// File: rtl/uflag_decide.sv
module uflag_decide
    import usr_irq_flag_pkg::*;
(
    input  logic            op_valid,
    input  uflag_op_e       op,
    input  core_mode_t      mode,
    output uflag_decision_t dec
);
    always_comb begin
        dec = '{act: ACT_IDLE, new_val: 1'b0, abort_is_set: 1'b0};
        if (op_valid && op != OP_NONE) begin
            if (mode_forbids(mode)) begin
                dec.act = ACT_FAULT;
            end else if (op == OP_TEST) begin
                dec.act = ACT_REPORT;
            end else if (mode.in_txn) begin
                dec.act          = ACT_ABORT;
                dec.abort_is_set = (op == OP_SET);
            end else begin
                dec.act     = ACT_WRITE;
                dec.new_val = (op == OP_SET);
            end
        end
    end
endmodule

// File: rtl/uflag_store.sv
module uflag_store
    import usr_irq_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  uflag_act_e act,
    input  logic       new_val,
    output logic       flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (act == ACT_WRITE) begin
            flag <= new_val;
        end
    end
endmodule

// File: rtl/uflag_report.sv
module uflag_report
    import usr_irq_flag_pkg::*;
#(
    parameter int                 CODE_W   = 32,
    parameter logic [CODE_W-1:0]  CODE_CLR = 32'h0000_0101,
    parameter logic [CODE_W-1:0]  CODE_SET = 32'h0000_0103
) (
    input  logic              clk,
    input  logic              rst,
    input  uflag_act_e        act,
    input  logic              abort_is_set,
    input  logic              cur_flag,
    output logic              exc_p,
    output logic              abort_p,
    output logic [CODE_W-1:0] code,
    output logic              rep_p,
    output logic              rep_val,
    output arith_flags_t      rep_flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            exc_p     <= 1'b0;
            abort_p   <= 1'b0;
            code      <= '0;
            rep_p     <= 1'b0;
            rep_val   <= 1'b0;
            rep_flags <= '0;
        end else begin
            exc_p     <= (act == ACT_FAULT);
            abort_p   <= (act == ACT_ABORT);
            rep_p     <= (act == ACT_REPORT);
            code      <= '0;
            rep_val   <= 1'b0;
            rep_flags <= '0;
            if (act == ACT_ABORT) begin
                code <= abort_is_set ? CODE_SET : CODE_CLR;
            end
            if (act == ACT_REPORT) begin
                rep_val   <= cur_flag;
                rep_flags <= report_flags(cur_flag);
            end
        end
    end
endmodule

// File: rtl/usr_irq_flag_ctl.sv
module usr_irq_flag_ctl
    import usr_irq_flag_pkg::*;
#(
    parameter int                 CODE_W   = 32,
    parameter logic [CODE_W-1:0]  CODE_CLR = 32'h0000_0101,
    parameter logic [CODE_W-1:0]  CODE_SET = 32'h0000_0103
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_sel,
    input  logic              feat_en,
    input  logic              long_mode,
    input  logic              in_enclave,
    input  logic              in_txn,
    output logic              flag_q,
    output logic              deliver_gate,
    output logic              ud_exc,
    output logic              txn_abort,
    output logic [CODE_W-1:0] abort_code,
    output logic              test_vld,
    output logic              test_result,
    output logic [5:0]        test_flags
);
    localparam int FLAGS_W = $bits(arith_flags_t);

    core_mode_t      mode;
    uflag_decision_t dec;
    arith_flags_t    flags_s;

    assign mode = '{feat_en: feat_en, long_mode: long_mode,
                    in_enclave: in_enclave, in_txn: in_txn};

    uflag_decide u_decide (
        .op_valid (op_valid),
        .op       (uflag_op_e'(op_sel)),
        .mode     (mode),
        .dec      (dec)
    );

    uflag_store u_store (
        .clk     (clk),
        .rst     (rst),
        .act     (dec.act),
        .new_val (dec.new_val),
        .flag    (flag_q)
    );

    uflag_report #(
        .CODE_W   (CODE_W),
        .CODE_CLR (CODE_CLR),
        .CODE_SET (CODE_SET)
    ) u_report (
        .clk          (clk),
        .rst          (rst),
        .act          (dec.act),
        .abort_is_set (dec.abort_is_set),
        .cur_flag     (flag_q),
        .exc_p        (ud_exc),
        .abort_p      (txn_abort),
        .code         (abort_code),
        .rep_p        (test_vld),
        .rep_val      (test_result),
        .rep_flags    (flags_s)
    );

    assign test_flags   = FLAGS_W'(flags_s);
    assign deliver_gate = flag_q;
endmodule

// File: rtl/usr_irq_flag_chk.sv
module usr_irq_flag_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [1:0]  op_sel,
    input logic        feat_en,
    input logic        long_mode,
    input logic        in_enclave,
    input logic        in_txn,
    input logic        flag_q,
    input logic        deliver_gate,
    input logic        ud_exc,
    input logic        txn_abort,
    input logic [31:0] abort_code,
    input logic        test_vld,
    input logic        test_result,
    input logic [5:0]  test_flags
);
    logic legal;
    assign legal = feat_en && long_mode && !in_enclave;

    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b01 && legal && !in_txn) |=> !flag_q);

    p_set_r1: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b10 && legal && !in_txn) |=> flag_q);

    p_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b01 && legal && !in_txn) |=> !deliver_gate);

    p_fault_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel != 2'b00 && !legal) |=> (ud_exc && !txn_abort && $stable(flag_q)));

    p_abort_code_r4: assert property (@(posedge clk) disable iff (rst)
        txn_abort |-> (abort_code == 32'h0000_0101 || abort_code == 32'h0000_0103));

    p_abort_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel[0] != op_sel[1] && legal && in_txn) |=> (txn_abort && $stable(flag_q)));

    p_report_r5: assert property (@(posedge clk) disable iff (rst)
        test_vld |-> (test_flags[5:1] == 5'b0 && test_flags[0] == test_result));

    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op_sel == 2'b00) |=> (!ud_exc && !txn_abort && !test_vld && $stable(flag_q)));

    p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ud_exc, txn_abort, test_vld}));

    p_single_r8: assert property (@(posedge clk) disable iff (rst)
        (!op_valid) |=> !(ud_exc || txn_abort || test_vld));
endmodule

bind usr_irq_flag_ctl usr_irq_flag_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_valid     (op_valid),
    .op_sel       (op_sel),
    .feat_en      (feat_en),
    .long_mode    (long_mode),
    .in_enclave   (in_enclave),
    .in_txn       (in_txn),
    .flag_q       (flag_q),
    .deliver_gate (deliver_gate),
    .ud_exc       (ud_exc),
    .txn_abort    (txn_abort),
    .abort_code   (abort_code),
    .test_vld     (test_vld),
    .test_result  (test_result),
    .test_flags   (test_flags)
);

// File: tb/test_usr_irq_flag_ctl.sv
module test_usr_irq_flag_ctl;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] EXP_CLR = 32'h0000_0101;
    localparam logic [31:0] EXP_SET = 32'h0000_0103;
    localparam int NVEC = 15;
    // [11] feat [10] long [9] enclave [8] txn [7:6] op |
    // [5] flag [4] exc [3] abort [2] abort-by-set [1] report [0] carry
    localparam logic [11:0] VEC [NVEC] = '{
        12'b1100_10_100000, 12'b1100_11_100011, 12'b1101_11_100011,
        12'b1101_01_101000, 12'b1101_10_101100, 12'b0100_01_110000,
        12'b1000_01_110000, 12'b1110_01_110000, 12'b0100_11_110000,
        12'b1100_00_100000, 12'b1100_01_000000, 12'b1100_11_000010,
        12'b1100_01_000000, 12'b1111_10_010000, 12'b1100_10_100000
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0;
    logic [1:0] op_sel = 2'b00;
    logic feat_en = 1'b0, long_mode = 1'b0, in_enclave = 1'b0, in_txn = 1'b0;
    logic flag_q, deliver_gate, ud_exc, txn_abort, test_vld, test_result;
    logic [31:0] abort_code;
    logic [5:0] test_flags;
    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usr_irq_flag_ctl i_usr_irq_flag_ctl (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .feat_en(feat_en), .long_mode(long_mode), .in_enclave(in_enclave),
        .in_txn(in_txn), .flag_q(flag_q), .deliver_gate(deliver_gate),
        .ud_exc(ud_exc), .txn_abort(txn_abort), .abort_code(abort_code),
        .test_vld(test_vld), .test_result(test_result), .test_flags(test_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [3:0] m, input logic [1:0] op, input logic v);
        @(negedge clk);
        {feat_en, long_mode, in_enclave, in_txn} = m;
        op_sel = op;
        op_valid = v;
        @(negedge clk);
        op_valid = 1'b0;
        op_sel = 2'b00;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7 flag", 32'(flag_q), 0);
        check("R7 gate", 32'(deliver_gate), 0);
        check("R7 pulses", 32'({ud_exc, txn_abort, test_vld}), 0);
        check("R7 code", abort_code, 0);
        check("R7 flags", 32'(test_flags), 0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] v;
            v = VEC[i];
            strobe(v[11:8], v[7:6], 1'b1);
            check("R1 flag", 32'(flag_q), 32'(v[5]));
            check("R2 gate", 32'(deliver_gate), 32'(v[5]));
            check("R3 exc", 32'(ud_exc), 32'(v[4]));
            check("R4 abort", 32'(txn_abort), 32'(v[3]));
            check("R4 code", abort_code, v[3] ? (v[2] ? EXP_SET : EXP_CLR) : 32'h0);
            check("R5 report", 32'(test_vld), 32'(v[1]));
            check("R5 result", 32'(test_result), 32'(v[1] & v[0]));
            check("R5 flags", 32'(test_flags), v[1] ? 32'(v[0]) : 32'h0);
        end

        // R6: strobe low with a legal clear pending: flag stays 1
        strobe(4'b1100, 2'b01, 1'b0);
        check("R6 flag held", 32'(flag_q), 1);
        check("R6 no pulse", 32'({ud_exc, txn_abort, test_vld}), 0);

        // R8: report pulse lasts one cycle
        strobe(4'b1100, 2'b11, 1'b1);
        check("R8 pulse on", 32'(test_vld), 1);
        check("R5 carry", 32'(test_flags), 1);
        @(negedge clk);
        check("R8 pulse off", 32'(test_vld), 0);
        check("R8 flags clear", 32'(test_flags), 0);

        // R8: fault pulse lasts one cycle
        strobe(4'b0000, 2'b10, 1'b1);
        check("R8 exc on", 32'(ud_exc), 1);
        @(negedge clk);
        check("R8 exc off", 32'(ud_exc), 0);

        // R7: reset while flag is set
        rst = 1'b1;
        @(negedge clk);
        check("R7 reset clears flag", 32'(flag_q), 0);
        check("R7 reset clears gate", 32'(deliver_gate), 0);
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule